// File: doc/BRIEF.md
# Reset Source Controller with Cause Flags

This block generates the reset controls of a small processor and keeps a two-bit record of why the last reset happened. Four event sources feed it. The first is a power-on indication, which is also the block's own asynchronous reset. The second is an active-low external reset pin, brought into the clock domain through a flop chain. The third is a single-cycle watchdog expiry pulse. The fourth is a level from the core saying it is halted. Software can also wipe the record through a clear input.

There are two kinds of reset. A full reset clears the whole chip. A warm reset clears only the program counter and the stack pointer. A watchdog expiry while the core is halted gives a warm reset. Every other event gives a full reset. Whichever kind is started, its output is held for a start-up window of `STARTUP_CYCLES` clocks so that the oscillator can settle. The two flags tell software what happened. `wdt_flag_o` is set by a watchdog expiry. `halt_flag_o` is set when the core was halted as the event arrived. Some events leave the flags as they were. The flags are read by software and need no other handshake.

Top module: `reset_cause_ctrl`

## Requirements
- R1: While `por_i` is high, `chip_rst_o`=1, `warm_rst_o`=0 and both flags are 0. After `por_i` falls, `chip_rst_o` goes low after exactly `STARTUP_CYCLES` rising edges.
- R2: The pin is synchronised through `SYNC_STAGES` flops. A low pin is seen at the (`SYNC_STAGES`+1)-th rising edge. From that edge on, `chip_rst_o` is high for as long as the pin stays low. After the pin goes back high, `chip_rst_o` goes low after exactly `SYNC_STAGES`+`STARTUP_CYCLES` rising edges.
- R3: If `halted_i`=0 at the edge where a low pin is first seen, both flags keep their values.
- R4: If `halted_i`=1 at the edge where a low pin is first seen, the flags become wdt=0 and halt=1.
- R5: A watchdog pulse that is accepted with `halted_i`=0 sets wdt=1 and leaves the halt flag as it was. `chip_rst_o` rises after that edge and goes low after `STARTUP_CYCLES` edges.
- R6: A watchdog pulse that is accepted with `halted_i`=1 sets both flags to 1. `warm_rst_o` is high for `STARTUP_CYCLES` cycles, and `chip_rst_o` stays 0.
- R7: A watchdog pulse is ignored while either reset output is high. It changes no flag and does not lengthen the current window.
- R8: `clr_flags_i`=1 zeroes both flags at the next edge. If a reset event is recognised in the same cycle, the event decides the flags and the clear has no effect.
- R9: `chip_rst_o` and `warm_rst_o` are never high together. A low pin seen during a warm window turns it into a full reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| rst_pin_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_expire_i | input | 1 | Watchdog expiry, one-cycle pulse |
| halted_i | input | 1 | Core is in its halted state |
| clr_flags_i | input | 1 | Software clear of both flags |
| chip_rst_o | output | 1 | Full chip reset |
| warm_rst_o | output | 1 | Reset of program counter and stack pointer only |
| wdt_flag_o | output | 1 | Last reset involved a watchdog expiry |
| halt_flag_o | output | 1 | Core was halted when the last event arrived |

## Verification
The bench asserts a clear in the exact cycle where a pin event is recognised. A design that lets the clear win would zero flags that must stay unchanged. It sends a watchdog pulse in the middle of the window that follows a pin release. A design that accepts it would raise a warm reset or set the flags, and would lengthen the window. It pulls the pin low during a warm window. A design that fails to promote it to a full reset, or that lets both outputs be high at once, is caught. Window lengths are counted edge by edge from the pin release, the watchdog pulse and the power-on release, so an off-by-one in the counter or in the synchroniser depth shows up. A random phase is compared, cycle by cycle, against a model kept in the bench.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_FULL = 2'd1,
    WIN_WARM = 2'd2
  } win_e;

  typedef enum logic [2:0] {
    EV_NONE     = 3'd0,
    EV_PIN_RUN  = 3'd1,
    EV_PIN_HALT = 3'd2,
    EV_WDT_RUN  = 3'd3,
    EV_WDT_HALT = 3'd4
  } ev_e;

  typedef struct packed {
    logic wdt;
    logic halt;
  } cause_t;

  // Flag update: a recognised event always beats the software clear.
  function automatic cause_t next_cause(ev_e ev, logic clr, cause_t cur);
    cause_t n;
    n = cur;
    case (ev)
      EV_PIN_RUN:  n = cur;
      EV_PIN_HALT: begin n.wdt = 1'b0; n.halt = 1'b1; end
      EV_WDT_RUN:  n.wdt = 1'b1;
      EV_WDT_HALT: begin n.wdt = 1'b1; n.halt = 1'b1; end
      default:     if (clr) n = '0;
    endcase
    return n;
  endfunction

  // Number of rising edges from pin release until the full reset drops.
  function automatic int unsigned release_edges(int unsigned stages, int unsigned win);
    return stages + win;
  endfunction

endpackage

// File: rtl/rcc_pin_sync.sv
module rcc_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_i,
  input  logic pin_n_i,
  output logic low_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              low_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge por_i) begin
        if (por_i) chain <= '1;
        else       chain <= pin_n_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or posedge por_i) begin
        if (por_i) chain <= '1;
        else       chain <= {chain[STAGES-2:0], pin_n_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) low_q <= 1'b0;
    else       low_q <= low_o;
  end

  assign low_o  = ~chain[STAGES-1];
  assign fall_o = low_o & ~low_q;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (por_i)
    fall_o |=> !fall_o); // R2

endmodule

// File: rtl/rcc_event_classify.sv
module rcc_event_classify
  import rcc_pkg::*;
(
  input  logic clk,
  input  logic por_i,
  input  logic pin_low_i,
  input  logic pin_fall_i,
  input  logic wdt_i,
  input  logic halted_i,
  input  logic win_idle_i,
  output ev_e  ev_o,
  output logic load_full_o,
  output logic load_warm_o,
  output logic wdt_dropped_o
);
  logic wdt_taken;

  always_comb begin
    wdt_taken     = wdt_i & win_idle_i & ~pin_low_i;
    wdt_dropped_o = wdt_i & ~wdt_taken;
    ev_o          = EV_NONE;
    if (pin_fall_i)     ev_o = halted_i ? EV_PIN_HALT : EV_PIN_RUN;
    else if (wdt_taken) ev_o = halted_i ? EV_WDT_HALT : EV_WDT_RUN;
    load_full_o = pin_low_i | (wdt_taken & ~halted_i);
    load_warm_o = wdt_taken & halted_i;
  end

  AST_LOADS_EXCLUSIVE: assert property (@(posedge clk) disable iff (por_i)
    !(load_full_o && load_warm_o)); // R9
  AST_BUSY_DROPS_WDT: assert property (@(posedge clk) disable iff (por_i)
    (wdt_i && !win_idle_i) |-> wdt_dropped_o); // R7

endmodule

// File: rtl/rcc_startup_timer.sv
module rcc_startup_timer
  import rcc_pkg::*;
#(
  parameter int unsigned STARTUP_CYCLES = 1024
) (
  input  logic clk,
  input  logic por_i,
  input  logic load_full_i,
  input  logic load_warm_i,
  output win_e win_o
);
  localparam int unsigned CNT_W = $clog2(STARTUP_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      win_o <= WIN_FULL;
      cnt   <= CNT_W'(STARTUP_CYCLES);
    end else if (load_full_i) begin
      win_o <= WIN_FULL;
      cnt   <= CNT_W'(STARTUP_CYCLES);
    end else if (load_warm_i) begin
      win_o <= WIN_WARM;
      cnt   <= CNT_W'(STARTUP_CYCLES);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) win_o <= WIN_IDLE;
    end
  end

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (por_i)
    (cnt != '0 && !load_full_i && !load_warm_i) |=> cnt == $past(cnt) - CNT_W'(1)); // R5
  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (por_i)
    load_full_i |=> (win_o == WIN_FULL && cnt == CNT_W'(STARTUP_CYCLES))); // R2
  AST_WARM_LOAD: assert property (@(posedge clk) disable iff (por_i)
    load_warm_i |=> (win_o == WIN_WARM && cnt == CNT_W'(STARTUP_CYCLES))); // R6

endmodule

// File: rtl/rcc_cause_flags.sv
module rcc_cause_flags
  import rcc_pkg::*;
(
  input  logic   clk,
  input  logic   por_i,
  input  ev_e    ev_i,
  input  logic   clr_i,
  output cause_t flags_o
);
  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) flags_o <= '0;
    else       flags_o <= next_cause(ev_i, clr_i, flags_o);
  end

  AST_PIN_RUN_KEEPS: assert property (@(posedge clk) disable iff (por_i)
    (ev_i == EV_PIN_RUN) |=> $stable(flags_o)); // R3
  AST_PIN_HALT_SET: assert property (@(posedge clk) disable iff (por_i)
    (ev_i == EV_PIN_HALT) |=> (!flags_o.wdt && flags_o.halt)); // R4
  AST_WDT_RUN_SET: assert property (@(posedge clk) disable iff (por_i)
    (ev_i == EV_WDT_RUN) |=> (flags_o.wdt && flags_o.halt == $past(flags_o.halt))); // R5
  AST_WDT_HALT_SET: assert property (@(posedge clk) disable iff (por_i)
    (ev_i == EV_WDT_HALT) |=> (flags_o.wdt && flags_o.halt)); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (por_i)
    (clr_i && ev_i == EV_NONE) |=> (flags_o == '0)); // R8

endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int unsigned STARTUP_CYCLES = 1024,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic por_i,
  input  logic rst_pin_n_i,
  input  logic wdt_expire_i,
  input  logic halted_i,
  input  logic clr_flags_i,
  output logic chip_rst_o,
  output logic warm_rst_o,
  output logic wdt_flag_o,
  output logic halt_flag_o
);
  logic   pin_low;
  logic   pin_fall;
  ev_e    ev;
  logic   load_full;
  logic   load_warm;
  logic   wdt_dropped;
  win_e   win;
  cause_t flags;

  rcc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .por_i   (por_i),
    .pin_n_i (rst_pin_n_i),
    .low_o   (pin_low),
    .fall_o  (pin_fall)
  );

  rcc_event_classify u_cls (
    .clk           (clk),
    .por_i         (por_i),
    .pin_low_i     (pin_low),
    .pin_fall_i    (pin_fall),
    .wdt_i         (wdt_expire_i),
    .halted_i      (halted_i),
    .win_idle_i    (win == WIN_IDLE),
    .ev_o          (ev),
    .load_full_o   (load_full),
    .load_warm_o   (load_warm),
    .wdt_dropped_o (wdt_dropped)
  );

  rcc_startup_timer #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_tmr (
    .clk         (clk),
    .por_i       (por_i),
    .load_full_i (load_full),
    .load_warm_i (load_warm),
    .win_o       (win)
  );

  rcc_cause_flags u_flg (
    .clk     (clk),
    .por_i   (por_i),
    .ev_i    (ev),
    .clr_i   (clr_flags_i),
    .flags_o (flags)
  );

  assign chip_rst_o  = (win == WIN_FULL);
  assign warm_rst_o  = (win == WIN_WARM);
  assign wdt_flag_o  = flags.wdt;
  assign halt_flag_o = flags.halt;

  AST_NO_DUAL_RESET: assert property (@(posedge clk) disable iff (por_i)
    !(chip_rst_o && warm_rst_o)); // R9
  AST_PIN_HOLDS_FULL: assert property (@(posedge clk) disable iff (por_i)
    pin_low |=> chip_rst_o); // R2
  AST_IGNORED_WDT: assert property (@(posedge clk) disable iff (por_i)
    (wdt_dropped && !pin_fall && !clr_flags_i) |=> ($stable(wdt_flag_o) && $stable(halt_flag_o))); // R7
  AST_WARM_ONLY_HALTED: assert property (@(posedge clk) disable iff (por_i)
    ($rose(warm_rst_o)) |-> ($past(halted_i) && $past(wdt_expire_i))); // R6

endmodule

// File: tb/test_reset_cause_ctrl.sv
module test_reset_cause_ctrl;
  localparam int unsigned N = 1024;
  localparam int unsigned S = 2;

  logic clk = 1'b0;
  logic por = 1'b1, pin = 1'b1, wdt = 1'b0, halted = 1'b0, clr = 1'b0;
  logic chip, warm, fw, fh;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  reset_cause_ctrl #(.STARTUP_CYCLES(N), .SYNC_STAGES(S)) i_reset_cause_ctrl (
    .clk(clk), .por_i(por), .rst_pin_n_i(pin), .wdt_expire_i(wdt),
    .halted_i(halted), .clr_flags_i(clr), .chip_rst_o(chip),
    .warm_rst_o(warm), .wdt_flag_o(fw), .halt_flag_o(fh)
  );

  // Expected edge counts, restated from the requirements.
  function automatic int exp_por_edges();      return N;     endfunction
  function automatic int exp_wdt_edges();      return N + 1; endfunction
  function automatic int exp_release_edges();  return S + N; endfunction

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Cycle model kept in the bench
  logic [S-1:0] mh;
  bit mlowq, mto, mpd;
  int mrem, mkind;   // 0 idle, 1 full, 2 warm

  always @(posedge clk) begin
    if (por) begin
      mh = '1; mlowq = 0; mkind = 1; mrem = N; mto = 0; mpd = 0;
    end else begin
      bit ls, pev, wok;
      ls  = !mh[S-1];
      pev = ls && !mlowq;
      wok = wdt && (mkind == 0) && !ls;
      if (pev) begin
        if (halted) begin mto = 0; mpd = 1; end
      end else if (wok) begin
        mto = 1;
        if (halted) mpd = 1;
      end else if (clr) begin
        mto = 0; mpd = 0;
      end
      if (ls) begin mkind = 1; mrem = N; end
      else if (wok) begin mkind = halted ? 2 : 1; mrem = N; end
      else if (mrem != 0) begin
        mrem--;
        if (mrem == 0) mkind = 0;
      end
      mh = {mh[S-2:0], pin};
      mlowq = ls;
    end
  end

  always @(negedge clk) begin
    chk(cur_req, int'(chip), int'(por || mkind == 1), "model full reset");
    chk(cur_req, int'(warm), int'(mkind == 2), "model warm reset");
    chk(cur_req, int'(fw), int'(mto), "model wdt flag");
    chk(cur_req, int'(fh), int'(mpd), "model halt flag");
    chk("R9", int'(chip && warm), 0, "both resets high");
  end

  // Count edges until the chosen output is low; n holds edges already seen.
  task automatic wait_low(bit use_warm, inout int n);
    while ((use_warm ? warm : chip) && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_wdt(bit h);
    halted = h;
    wdt = 1'b1;
    @(negedge clk);
    wdt = 1'b0;
  endtask

  int n;

  initial begin
    void'($urandom(32'd1234));
    // R1: power-on
    repeat (4) @(negedge clk);
    chk("R1", int'(chip), 1, "chip during por");
    chk("R1", int'(warm), 0, "warm during por");
    chk("R1", int'({fw, fh}), 0, "flags during por");
    por = 1'b0;
    n = 0;
    wait_low(1'b0, n);
    chk("R1", n, exp_por_edges(), "edges to release after por");

    // R5: watchdog while running
    cur_req = "R5";
    repeat (3) @(negedge clk);
    pulse_wdt(1'b0);
    chk("R5", int'(chip), 1, "full reset after wdt");
    chk("R5", int'({fw, fh}), 2, "flags wdt=1 halt=0");
    n = 1;
    wait_low(1'b0, n);
    chk("R5", n, exp_wdt_edges(), "wdt window edges");

    // R3 and R8: pin event while running, clear in the same cycle loses
    cur_req = "R3";
    pin = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", int'(chip), 0, "no reset before detection edge");
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R2", int'(chip), 1, "pin low detected on third edge");
    chk("R3", int'({fw, fh}), 2, "flags unchanged by running pin reset");
    chk("R8", int'(fw), 1, "clear lost against same-cycle event");
    repeat (6) @(negedge clk);
    chk("R2", int'(chip), 1, "held while pin low");
    pin = 1'b1;
    n = 0;
    wait_low(1'b0, n);
    chk("R2", n, exp_release_edges(), "edges from pin release");

    // R8: plain clear
    cur_req = "R8";
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R8", int'({fw, fh}), 0, "clear zeroes flags");

    // R4: pin while halted
    cur_req = "R4";
    halted = 1'b1;
    pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4", int'({fw, fh}), 1, "pin halted gives wdt=0 halt=1");
    repeat (3) @(negedge clk);
    pin = 1'b1;
    halted = 1'b0;
    n = 0;
    wait_low(1'b0, n);
    chk("R2", n, exp_release_edges(), "edges from pin release (halted)");

    // R5: halt flag kept when it was 1
    cur_req = "R5";
    pulse_wdt(1'b0);
    chk("R5", int'({fw, fh}), 3, "wdt sets wdt flag, keeps halt=1");
    n = 1;
    wait_low(1'b0, n);

    // R6: watchdog while halted -> warm reset
    cur_req = "R6";
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    pulse_wdt(1'b1);
    chk("R6", int'(warm), 1, "warm reset asserted");
    chk("R6", int'(chip), 0, "full reset stays low");
    chk("R6", int'({fw, fh}), 3, "flags both 1");
    n = 1;
    wait_low(1'b1, n);
    chk("R6", n, exp_wdt_edges(), "warm window edges");
    halted = 1'b0;

    // R7: watchdog during a full window is ignored
    cur_req = "R7";
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    pin = 1'b0;
    repeat (4) @(negedge clk);
    pin = 1'b1;
    n = 0;
    repeat (100) begin @(negedge clk); n++; end
    pulse_wdt(1'b1);
    n++;
    chk("R7", int'(warm), 0, "no warm reset from ignored wdt");
    chk("R7", int'({fw, fh}), 0, "flags untouched by ignored wdt");
    halted = 1'b0;
    wait_low(1'b0, n);
    chk("R7", n, exp_release_edges(), "window not lengthened");

    // R9: pin during warm window becomes full reset
    cur_req = "R9";
    pulse_wdt(1'b1);
    halted = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9", int'(warm), 1, "warm window running");
    pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", int'(chip), 1, "pin promotes to full reset");
    chk("R9", int'(warm), 0, "warm dropped");
    chk("R3", int'({fw, fh}), 3, "running pin keeps flags");
    pin = 1'b1;
    n = 0;
    wait_low(1'b0, n);
    chk("R2", n, exp_release_edges(), "release after promotion");

    // Random phase checked by the cycle model
    cur_req = "R9 random";
    begin
      int hold = 0;
      for (int i = 0; i < 20000; i++) begin
        @(negedge clk);
        wdt = ($urandom % 150 == 0);
        clr = ($urandom % 60 == 0);
        if ($urandom % 80 == 0) halted = ~halted;
        if (hold > 0) hold--;
        else if ($urandom % 1500 == 0) begin pin = 1'b0; hold = 1 + $urandom % 6; end
        else pin = 1'b1;
      end
    end
    wdt = 1'b0; clr = 1'b0; pin = 1'b1;
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule